// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block bridges a clocked, single-master request port to an external asynchronous static RAM holding 256K words of 16 bits, split into a lower byte lane (bits 7:0) and an upper byte lane (bits 15:8). A request carries an address, a write flag, a two-bit byte mask and write data. The controller turns each request into a sequence of active-low pin levels on the memory: chip select, output enable, write enable and one strobe per byte lane. It also drives a split data bus made of outgoing data, incoming data and a drive enable that a pad cell outside this block uses.

Every phase length is a whole number of clock cycles. Each one is worked out at elaboration from the clock period and a speed-grade selector (55 ns or 70 ns parts). The result is the ceiling of the required nanoseconds divided by the period, and never less than one cycle. Reads end with a turnaround phase, so the memory has released the bus before anything else happens. Writes keep output enable high throughout, and the controller drives the bus only while write enable is low and for one hold cycle after it. Between requests, chip select and both lane strobes sit high, so the memory rests in standby.

The request port is valid/ready. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` then drops and stays low until the access has fully completed, so back-pressure lasts for the whole memory cycle. The requester must hold its fields stable only in the accept cycle. Read data returns as a one-clock `rsp_valid` pulse with no back-pressure.

Top module: `sram_bus_ctrl`

## Requirements
- R1: After reset and whenever `req_ready` is high, `mem_cs_n`, `mem_oe_n`, `mem_we_n`, `mem_ub_n` and `mem_lb_n` are all high, `mem_dq_oe` is low and `rsp_valid` is low.
- R2: A request is accepted only on an edge with `req_valid` and `req_ready` both high. `req_ready` is low from the next cycle until the access completes. A `req_valid` raised while `req_ready` is low is ignored and causes no pin activity and no memory change.
- R3: A read holds `mem_cs_n` and `mem_oe_n` low, with `mem_we_n` high, for RD_CYC cycles (3 at a 20 ns clock and the 55 ns grade). It samples `mem_dq_in` on the edge that ends that phase and pulses `rsp_valid` for exactly one cycle right after.
- R4: Mask bit 0 selects the lower lane (`mem_lb_n` low, data bits 7:0) and mask bit 1 the upper lane (`mem_ub_n` low, bits 15:8). In `rsp_rdata`, a lane not selected reads as zero.
- R5: A write holds `mem_cs_n` and its lane strobes low for SET_CYC cycles with `mem_we_n` high (1 by default). It then holds `mem_we_n` low for WE_CYC cycles (2 by default) while driving `mem_dq_out` equal to the write data. One hold cycle follows that keeps driving, with chip select and strobes high. `mem_oe_n` stays high throughout, and `req_ready` returns 5 cycles after acceptance by default.
- R6: During a write only the lanes selected by the mask have their strobe low, so a lane not selected keeps its stored byte.
- R7: A request with an all-zero mask asserts no chip select or strobe, produces no `rsp_valid`, and holds `req_ready` low for exactly one cycle.
- R8: After each read, at least TURN_CYC cycles pass with `mem_oe_n` high and all strobes high before `req_ready` returns. `mem_we_n` never falls in a cycle that follows one with `mem_oe_n` low.
- R9: `mem_dq_oe` is never high while `mem_oe_n` is low, and it is high only during the write-enable phase and the write hold phase.
- R10: `mem_addr` holds the accepted address unchanged for as long as `mem_cs_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_be | input | 2 | Byte mask, bit 0 lower lane, bit 1 upper lane |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | One-cycle read data strobe |
| rsp_rdata | output | 16 | Read data, lanes not selected are zero |
| mem_addr | output | 18 | Memory address pins |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_ub_n | output | 1 | Upper lane strobe, active low |
| mem_lb_n | output | 1 | Lower lane strobe, active low |
| mem_dq_out | output | 16 | Data toward the memory |
| mem_dq_in | input | 16 | Data from the memory |
| mem_dq_oe | output | 1 | Drive enable for the data pads |

## Verification
Each result has a fixed cycle after the acceptance edge. At defaults, read strobes hold for the first three cycles, `rsp_valid` rises in the fourth cycle and `req_ready` returns in the fifth. A write holds chip select for three cycles, write enable in the second and third, and drive through the fourth, with ready back in the fifth. An empty request gives ready back in the second. The bench drives on falling edges and samples every cycle at the falling edge after acceptance, counting cycle indices from there. It compares the exact index of each event and the number of cycles each pin spends low with these figures. A behavioural memory in the bench stores bytes only under low lane strobes, which lets read-back catch errors in lane masking and in ignored requests.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  localparam int DATA_W = 16;
  localparam int LANE_W = 8;
  localparam int LANES  = DATA_W / LANE_W;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD,
    ST_TURN,
    ST_WSET,
    ST_WPULSE,
    ST_WHOLD,
    ST_EMPTY
  } ctrl_state_t;

  typedef struct packed {
    logic             cs_n;
    logic             oe_n;
    logic             we_n;
    logic [LANES-1:0] lane_n;
    logic             dq_oe;
  } pin_set_t;

  function automatic int cyc_of(input int ns, input int period);
    int c;
    c = (ns + period - 1) / period;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (load)         cnt_q <= load_val;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign done = (cnt_q == '0);

  // Phase counting for R3 and R5: an unloaded nonzero count steps down by one.
  assert_count_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/sram_pin_decode.sv
module sram_pin_decode
  import sram_ctrl_pkg::*;
(
  input  ctrl_state_t      state,
  input  logic [LANES-1:0] be,
  output pin_set_t         pins
);

  always_comb begin
    pins.cs_n   = 1'b1;
    pins.oe_n   = 1'b1;
    pins.we_n   = 1'b1;
    pins.lane_n = '1;
    pins.dq_oe  = 1'b0;
    unique case (state)
      ST_RD: begin
        pins.cs_n   = 1'b0;
        pins.oe_n   = 1'b0;
        pins.lane_n = ~be;
      end
      ST_WSET: begin
        pins.cs_n   = 1'b0;
        pins.lane_n = ~be;
      end
      ST_WPULSE: begin
        pins.cs_n   = 1'b0;
        pins.we_n   = 1'b0;
        pins.lane_n = ~be;
        pins.dq_oe  = 1'b1;
      end
      ST_WHOLD: begin
        pins.dq_oe  = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/sram_bus_ctrl.sv
module sram_bus_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W        = 18,
  parameter int CLK_PERIOD_NS = 20,
  parameter bit GRADE_70      = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LANES-1:0]  req_be,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic              mem_ub_n,
  output logic              mem_lb_n,
  output logic [DATA_W-1:0] mem_dq_out,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic              mem_dq_oe
);

  // Memory timing figures in nanoseconds for the selected grade.
  localparam int T_AA   = GRADE_70 ? 70 : 55;
  localparam int T_WC   = GRADE_70 ? 70 : 55;
  localparam int T_PWE  = GRADE_70 ? 50 : 40;
  localparam int T_AW   = GRADE_70 ? 60 : 45;
  localparam int T_SD   = GRADE_70 ? 30 : 25;
  localparam int T_HZOE = GRADE_70 ? 25 : 20;
  localparam int T_OHA  = 10;

  localparam int RD_CYC   = cyc_of(T_AA, CLK_PERIOD_NS);
  localparam int WE_CYC   = imax(cyc_of(T_PWE, CLK_PERIOD_NS), cyc_of(T_SD, CLK_PERIOD_NS));
  localparam int AW_CYC   = cyc_of(T_AW, CLK_PERIOD_NS);
  localparam int SET_CYC  = imax(1, AW_CYC - WE_CYC);
  localparam int WC_CYC   = cyc_of(T_WC, CLK_PERIOD_NS);
  localparam int HOLD_CYC = imax(1, WC_CYC - SET_CYC - WE_CYC);
  localparam int TURN_CYC = imax(cyc_of(T_HZOE, CLK_PERIOD_NS), cyc_of(T_OHA, CLK_PERIOD_NS));
  localparam int MAX_CYC  = imax(imax(RD_CYC, TURN_CYC), imax(imax(SET_CYC, WE_CYC), HOLD_CYC));
  localparam int CNT_W    = $clog2(MAX_CYC + 1);

  ctrl_state_t       state_q, state_d;
  logic              accept;
  logic              phase_done;
  logic              timer_load;
  logic [CNT_W-1:0]  timer_val;
  logic [LANES-1:0]  be_q, be_d;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;
  logic [DATA_W-1:0] lane_mask;
  logic              rsp_q;
  pin_set_t          pins_d, pins_q;

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign be_d      = accept ? req_be : be_q;

  // Next state and the length of the phase being entered.
  always_comb begin
    state_d   = state_q;
    timer_val = '0;
    unique case (state_q)
      ST_IDLE: if (accept) begin
        if (req_be == '0) begin
          state_d = ST_EMPTY;
        end else if (req_write) begin
          state_d   = ST_WSET;
          timer_val = CNT_W'(SET_CYC - 1);
        end else begin
          state_d   = ST_RD;
          timer_val = CNT_W'(RD_CYC - 1);
        end
      end
      ST_RD: if (phase_done) begin
        state_d   = ST_TURN;
        timer_val = CNT_W'(TURN_CYC - 1);
      end
      ST_TURN:   if (phase_done) state_d = ST_IDLE;
      ST_WSET: if (phase_done) begin
        state_d   = ST_WPULSE;
        timer_val = CNT_W'(WE_CYC - 1);
      end
      ST_WPULSE: if (phase_done) begin
        state_d   = ST_WHOLD;
        timer_val = CNT_W'(HOLD_CYC - 1);
      end
      ST_WHOLD:  if (phase_done) state_d = ST_IDLE;
      ST_EMPTY:  state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  assign timer_load = (state_d != state_q);

  sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (timer_load),
    .load_val (timer_val),
    .done     (phase_done)
  );

  // Pins are decoded from the next state and registered, so they never glitch.
  sram_pin_decode u_decode (
    .state (state_d),
    .be    (be_d),
    .pins  (pins_d)
  );

  // Per-lane read mask: lanes not selected return zero.
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_mask[g*LANE_W +: LANE_W] = {LANE_W{be_q[g]}};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pins_q  <= '{cs_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, lane_n: '1, dq_oe: 1'b0};
      be_q    <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      rsp_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      pins_q  <= pins_d;
      rsp_q   <= 1'b0;
      if (accept) begin
        be_q    <= req_be;
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
      end
      if (state_q == ST_RD && phase_done) begin
        rdata_q <= mem_dq_in & lane_mask;
        rsp_q   <= 1'b1;
      end
    end
  end

  assign rsp_valid  = rsp_q;
  assign rsp_rdata  = rdata_q;
  assign mem_addr   = addr_q;
  assign mem_dq_out = wdata_q;
  assign mem_cs_n   = pins_q.cs_n;
  assign mem_oe_n   = pins_q.oe_n;
  assign mem_we_n   = pins_q.we_n;
  assign mem_ub_n   = pins_q.lane_n[1];
  assign mem_lb_n   = pins_q.lane_n[0];
  assign mem_dq_oe  = pins_q.dq_oe;

  assert_standby_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_cs_n && mem_oe_n && mem_we_n && mem_ub_n && mem_lb_n && !mem_dq_oe));

  assert_busy_after_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  assert_rsp_single_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  assert_we_within_select_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_cs_n && mem_oe_n && mem_dq_oe));

  assert_empty_no_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_be == '0) |=> (mem_cs_n && mem_ub_n && mem_lb_n && !rsp_valid));

  assert_turnaround_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> $past(mem_oe_n));

  assert_no_contention_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (!mem_dq_oe && mem_we_n));

  assert_addr_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr));

endmodule

// File: tb/sram_bus_ctrl_tb.sv
module sram_bus_ctrl_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [17:0] req_addr = '0;
  logic [1:0]  req_be = '0;
  logic [15:0] req_wdata = '0;
  logic        rsp_valid;
  logic [15:0] rsp_rdata;
  logic [17:0] mem_addr;
  logic        mem_cs_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n, mem_dq_oe;
  logic [15:0] mem_dq_out;
  logic [15:0] mem_dq_in;

  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;

  sram_bus_ctrl u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .mem_ub_n(mem_ub_n), .mem_lb_n(mem_lb_n),
    .mem_dq_out(mem_dq_out), .mem_dq_in(mem_dq_in), .mem_dq_oe(mem_dq_oe)
  );

  // Behavioural memory: stores a byte only while its strobe is low.
  logic [15:0] mdl [0:255];
  logic [15:0] exp_mem [0:255];

  initial begin
    for (int i = 0; i < 256; i++) begin
      mdl[i]     = 16'(i * 16'h0101) ^ 16'h5A3C;
      exp_mem[i] = 16'(i * 16'h0101) ^ 16'h5A3C;
    end
  end

  always @(posedge clk) begin
    if (!mem_cs_n && !mem_we_n) begin
      if (!mem_lb_n) mdl[mem_addr[7:0]][7:0]  <= mem_dq_out[7:0];
      if (!mem_ub_n) mdl[mem_addr[7:0]][15:8] <= mem_dq_out[15:8];
    end
  end

  always_comb begin
    if (!mem_cs_n && !mem_oe_n && mem_we_n)
      mem_dq_in = {mem_ub_n ? 8'hEE : mdl[mem_addr[7:0]][15:8],
                   mem_lb_n ? 8'hEE : mdl[mem_addr[7:0]][7:0]};
    else
      mem_dq_in = 16'hBEEF;
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Per-request observation, filled by run_req.
  int          m_cs, m_oe, m_we, m_drv, m_rsp, k_rsp, k_ready;
  int          bad_addr, bad_lane, bad_contend, bad_data, bad_turn;
  logic [15:0] m_rdata;

  task automatic run_req(input bit wr, input logic [17:0] a, input logic [1:0] be,
                         input logic [15:0] d);
    m_cs = 0; m_oe = 0; m_we = 0; m_drv = 0; m_rsp = 0; k_rsp = 0; k_ready = 0;
    bad_addr = 0; bad_lane = 0; bad_contend = 0; bad_data = 0; bad_turn = 0;
    m_rdata = '0;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_be = be; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    for (int k = 1; k <= 40; k++) begin
      if (!mem_cs_n) m_cs++;
      if (!mem_oe_n) m_oe++;
      if (!mem_we_n) m_we++;
      if (mem_dq_oe) begin
        m_drv++;
        if (mem_dq_out !== d) bad_data++;
      end
      if (rsp_valid) begin m_rsp++; k_rsp = k; m_rdata = rsp_rdata; end
      if (!mem_cs_n && mem_addr !== a) bad_addr++;
      if (!mem_cs_n && {mem_ub_n, mem_lb_n} !== ~be) bad_lane++;
      if (!mem_oe_n && mem_dq_oe) bad_contend++;
      if (!wr && m_oe > 0 && k > m_oe && (!mem_oe_n || !mem_ub_n || !mem_lb_n || req_ready)
          && k <= m_oe + 1) bad_turn++;
      if (req_ready) begin k_ready = k; break; end
      @(negedge clk);
    end
  endtask

  task automatic test_reset();
    chk("R1", "ready", int'(req_ready), 1);
    chk("R1", "idle pins", int'({mem_cs_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n}), 5'h1F);
    chk("R1", "drive off", int'(mem_dq_oe), 0);
    chk("R1", "rsp_valid", int'(rsp_valid), 0);
  endtask

  task automatic do_write(input logic [17:0] a, input logic [1:0] be, input logic [15:0] d);
    run_req(1'b1, a, be, d);
    if (be[0]) exp_mem[a[7:0]][7:0]  = d[7:0];
    if (be[1]) exp_mem[a[7:0]][15:8] = d[15:8];
    chk("R5", "cs low cycles", m_cs, 3);
    chk("R5", "we low cycles", m_we, 2);
    chk("R5", "oe low cycles", m_oe, 0);
    chk("R9", "drive cycles", m_drv, 3);
    chk("R5", "drive data mismatches", bad_data, 0);
    chk("R2", "ready return cycle", k_ready, 5);
    chk("R6", "lane strobe mismatches", bad_lane, 0);
    chk("R10", "address mismatches", bad_addr, 0);
    chk("R3", "no response on write", m_rsp, 0);
  endtask

  task automatic do_read(input logic [17:0] a, input logic [1:0] be);
    logic [15:0] e;
    run_req(1'b0, a, be, 16'h0000);
    e = {be[1] ? exp_mem[a[7:0]][15:8] : 8'h00, be[0] ? exp_mem[a[7:0]][7:0] : 8'h00};
    chk("R3", "cs low cycles", m_cs, 3);
    chk("R3", "oe low cycles", m_oe, 3);
    chk("R3", "we low cycles", m_we, 0);
    chk("R3", "rsp pulses", m_rsp, 1);
    chk("R3", "rsp cycle", k_rsp, 4);
    chk("R4", "read data", int'(m_rdata), int'(e));
    chk("R4", "lane strobe mismatches", bad_lane, 0);
    chk("R8", "ready return cycle", k_ready, 5);
    chk("R8", "turnaround violations", bad_turn, 0);
    chk("R9", "contention", bad_contend + m_drv, 0);
    chk("R10", "address mismatches", bad_addr, 0);
  endtask

  task automatic test_full_word();
    do_write(18'h00012, 2'b11, 16'hA5C3);
    do_read(18'h00012, 2'b11);
  endtask

  task automatic test_lanes();
    do_write(18'h3FFFF, 2'b01, 16'h1234);
    chk("R6", "upper byte kept", int'(mdl[8'hFF][15:8]), int'(exp_mem[8'hFF][15:8]));
    do_read(18'h3FFFF, 2'b10);
    do_read(18'h3FFFF, 2'b01);
    do_write(18'h20040, 2'b10, 16'h9900);
    do_read(18'h20040, 2'b11);
  endtask

  task automatic test_empty();
    run_req(1'b1, 18'h00012, 2'b00, 16'hFFFF);
    chk("R7", "cs low cycles", m_cs, 0);
    chk("R7", "ready return cycle", k_ready, 2);
    chk("R7", "rsp pulses", m_rsp, 0);
    run_req(1'b0, 18'h00012, 2'b00, 16'h0000);
    chk("R7", "read: cs low cycles", m_cs + m_oe, 0);
    chk("R7", "read: rsp pulses", m_rsp, 0);
    do_read(18'h00012, 2'b11);
  endtask

  task automatic test_busy_ignore();
    int stray;
    stray = 0;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 18'h00077; req_be = 2'b11;
    @(negedge clk);
    req_write = 1'b1; req_wdata = 16'h0BAD; req_be = 2'b11;
    @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (!req_ready) @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      if (!mem_cs_n || !mem_we_n || !req_ready) stray++;
      @(negedge clk);
    end
    chk("R2", "activity after ignored request", stray, 0);
    do_read(18'h00077, 2'b11);
  endtask

  task automatic test_read_then_write();
    do_read(18'h00005, 2'b11);
    do_write(18'h00005, 2'b11, 16'hC0DE);
    chk("R8", "write oe high", m_oe, 0);
    do_read(18'h00005, 2'b11);
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_full_word();
    test_lanes();
    test_empty();
    test_busy_ignore();
    test_read_then_write();
    summary();
    $finish;
  end

endmodule